// File: doc/BRIEF.md
# Triggered Stream-to-Hold Capture Buffer

This block keeps a rolling window of the most recent fixed-width samples in a 32-entry circular store. In its streaming modes every valid sample is written. Once the store is full, each new sample pushes out the oldest one and a sticky overrun flag is raised. In the triggered mode a trigger level, taken only on cycles that carry a valid sample, freezes the store so that the samples around an event are kept and can be read out later at leisure.

When the trigger arrives with the store already full, the block freezes after one more sample. That leaves thirty samples older than the event, the event sample itself and one sample after it. When the trigger arrives during the first fill, the block keeps filling. It freezes at the moment of reaching full only if the trigger is still high on that filling sample. Otherwise it goes on streaming and the event is lost. A consumer drains the store oldest-first through a pop strobe, and each entry carries a flag marking whether it was a trigger sample. Selecting bypass empties the store and clears all flags.

Top module: `trig_capture_fifo`

## Requirements
- R1: Mode encoding is 2'b00 bypass, 2'b01 plain stream, 2'b10 triggered, with 2'b11 treated as bypass. One cycle in bypass clears the count, overrun and frozen. Samples and pops offered in bypass have no effect.
- R2: In a streaming mode each valid sample adds one entry. A pop with a non-empty store returns the oldest entry on `rdData` and lowers the count by one. A pop with an empty store is ignored. `empty` is high exactly when the count is 0.
- R3: `overrun` rises in the cycle after the count first reaches 32 and stays high until bypass. A sample pushed while the count is 32 discards the oldest entry, and the count stays at 32.
- R4: A push and a pop in the same cycle with a full store keep the count at 32. The next oldest entry then appears on `rdData`.
- R5: In triggered mode, a trigger taken with the count at 32 lets exactly one further valid sample in and then freezes. The store then holds 30 pre-event samples, the trigger sample and one post-event sample, in that order.
- R6: In triggered mode, if the trigger is taken before the first fill and is still high on the sample that brings the count to 32, `frozen` rises in the cycle after that sample.
- R7: In triggered mode, if the trigger has dropped before the filling sample, the block does not freeze and keeps overwriting the oldest entries.
- R8: While frozen, valid samples are discarded and pops still drain entries. `frozen` stays high until bypass.
- R9: The trigger is sampled only in cycles with `sampleValid` high. In triggered mode each accepted sample with the trigger high is stored with its mark bit set, and the mark is seen on `rdIsTrig` when the entry is oldest.
- R10: In plain stream mode the trigger is ignored. The block never freezes and stores every mark bit as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode (see R1) |
| sampleValid | input | 1 | New sample present this cycle |
| sampleData | input | DATA_W | Sample word |
| trigIn | input | 1 | Trigger level, sampled with valid samples |
| popReq | input | 1 | Remove the oldest entry |
| rdData | output | DATA_W | Oldest stored sample |
| rdIsTrig | output | 1 | Oldest entry was a trigger sample |
| count | output | CNT_W | Unread entries, 0 to DEPTH |
| empty | output | 1 | Count is zero |
| overrun | output | 1 | Store has been full since last bypass |
| frozen | output | 1 | Capture frozen after a trigger |

## Verification
Two pairs of functions can land in the same cycle. A push on a full store can coincide with a pop. A trigger sample can coincide with the sample that completes the first fill. The bench drives a pop and a push together on a full store and expects the count to stay at 32 with the next oldest word exposed. It holds the trigger across the filling sample and expects the freeze on that exact sample, not one later. It also pushes while popping on a frozen store and expects the count to fall by one with the pushed word never appearing.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_STREAM = 2'b01,
    MODE_TRIG   = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic clear;     // reset both pointers
    logic write;     // store sample at write pointer, advance it
    logic advRead;   // advance read pointer (pop or overwrite of oldest)
    logic markTrig;  // stored entry is a trigger sample
  } strobe_t;

endpackage

// File: rtl/tcf_ctrl.sv
module tcf_ctrl
  import tcf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             sampleValid,
  input  logic             trigIn,
  input  logic             popReq,
  output strobe_t          stb,
  output logic [CNT_W-1:0] count,
  output logic             overrun,
  output logic             frozen
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);

  logic isBypass, trigMode, full;
  logic doPush, doPop, fillNow, trigSample, armPost, freezeNow;
  logic postPending;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    isBypass   = (mode == MODE_BYPASS) || (mode == MODE_RSVD);
    trigMode   = (mode == MODE_TRIG);
    full       = (count == FULL_CNT);
    doPush     = sampleValid && !isBypass && !frozen;
    doPop      = popReq && !isBypass && (count != '0);
    fillNow    = doPush && !doPop && (count == LAST_CNT);
    trigSample = doPush && trigMode && trigIn;
    armPost    = trigSample && full && !postPending;
    freezeNow  = (postPending && doPush && trigMode) || (trigSample && fillNow);

    if (full && doPush) countNext = FULL_CNT;
    else countNext = CNT_W'(count + CNT_W'(doPush) - CNT_W'(doPop));

    stb.clear    = isBypass;
    stb.write    = doPush;
    stb.advRead  = doPop || (doPush && full);
    stb.markTrig = trigSample;
  end

  always_ff @(posedge clk) begin
    if (!rstN || isBypass) begin
      count       <= '0;
      overrun     <= 1'b0;
      frozen      <= 1'b0;
      postPending <= 1'b0;
    end else begin
      count       <= countNext;
      overrun     <= overrun || (countNext == FULL_CNT);
      frozen      <= frozen || freezeNow;
      postPending <= trigMode && !frozen && !freezeNow && (postPending || armPost);
    end
  end

endmodule

// File: rtl/tcf_store.sv
module tcf_store
  import tcf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdIsTrig
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrInc, rdPtrInc;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrPtrInc = wrPtr + PTR_W'(1);
      assign rdPtrInc = rdPtr + PTR_W'(1);
    end else begin : g_wrap
      assign wrPtrInc = (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrInc = (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.write)   wrPtr <= wrPtrInc;
      if (stb.advRead) rdPtr <= rdPtrInc;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.write && !stb.clear) mem[wrPtr] <= {stb.markTrig, wrData};
  end

  assign rdData   = mem[rdPtr][DATA_W-1:0];
  assign rdIsTrig = mem[rdPtr][DATA_W];

endmodule

// File: rtl/trig_capture_fifo.sv
module trig_capture_fifo
  import tcf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              trigIn,
  input  logic              popReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdIsTrig,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              overrun,
  output logic              frozen
);

  strobe_t stb;

  tcf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .sampleValid(sampleValid),
    .trigIn(trigIn), .popReq(popReq), .stb(stb), .count(count),
    .overrun(overrun), .frozen(frozen)
  );

  tcf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(sampleData),
    .rdData(rdData), .rdIsTrig(rdIsTrig)
  );

  assign empty = (count == '0);

endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             sampleValid,
  input logic             popReq,
  input logic [CNT_W-1:0] count,
  input logic             overrun,
  input logic             frozen
);

  logic bypassSel;
  assign bypassSel = (mode == 2'b00) || (mode == 2'b11);

  AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    bypassSel |=> (count == '0) && !overrun && !frozen); // R1

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R2

  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassSel && !frozen && sampleValid && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH)); // R3

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !bypassSel) |=> overrun); // R3

  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !bypassSel) |=> frozen); // R8

  AST_FROZEN_POP_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !bypassSel && popReq && count != '0) |=> count == $past(count) - CNT_W'(1)); // R8

  AST_FROZEN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !bypassSel) |=> count <= $past(count)); // R8

  AST_STREAM_NEVER_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && !frozen) |=> !frozen); // R10

endmodule

bind trig_capture_fifo tcf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .sampleValid(sampleValid),
  .popReq(popReq), .count(count), .overrun(overrun), .frozen(frozen)
);

// File: tb/trig_capture_fifo_tb.sv
module trig_capture_fifo_tb;

  localparam int DEPTH  = 32;
  localparam int DATA_W = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              trigIn = 1'b0;
  logic              popReq = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              rdIsTrig;
  logic [CNT_W-1:0]  count;
  logic              empty, overrun, frozen;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  trig_capture_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .sampleValid(sampleValid),
    .sampleData(sampleData), .trigIn(trigIn), .popReq(popReq),
    .rdData(rdData), .rdIsTrig(rdIsTrig), .count(count), .empty(empty),
    .overrun(overrun), .frozen(frozen)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: inputs applied at a falling edge, results seen at the next
  task automatic cyc(input logic v, input int d, input logic t, input logic p);
    sampleValid = v; sampleData = DATA_W'(d); trigIn = t; popReq = p;
    @(negedge clk);
    sampleValid = 1'b0; trigIn = 1'b0; popReq = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    mode = m;
    cyc(1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic popExpect(input string tag, input int d, input int mark);
    check({tag, " data"}, int'(rdData), d);
    check({tag, " mark"}, int'(rdIsTrig), mark);
    cyc(1'b0, 0, 1'b0, 1'b1);
  endtask

  task automatic testReset();
    check("R1 reset count", int'(count), 0);
    check("R2 reset empty", int'(empty), 1);
    check("R1 reset overrun", int'(overrun), 0);
    check("R1 reset frozen", int'(frozen), 0);
  endtask

  task automatic testStream();
    setMode(2'b01);
    for (int i = 0; i < 5; i++) cyc(1'b1, 10 + i, 1'b0, 1'b0);
    check("R2 count after 5", int'(count), 5);
    check("R2 not empty", int'(empty), 0);
    for (int i = 0; i < 5; i++) popExpect("R2 oldest first", 10 + i, 0);
    check("R2 drained", int'(count), 0);
    cyc(1'b0, 0, 1'b0, 1'b1);
    check("R2 pop on empty ignored", int'(count), 0);
    check("R2 empty flag", int'(empty), 1);
  endtask

  task automatic testOverflow();
    setMode(2'b00);
    setMode(2'b01);
    for (int i = 0; i < 31; i++) cyc(1'b1, 100 + i, 1'b0, 1'b0);
    check("R3 no overrun at 31", int'(overrun), 0);
    cyc(1'b1, 131, 1'b0, 1'b0);
    check("R3 overrun at 32", int'(overrun), 1);
    for (int i = 32; i < 40; i++) cyc(1'b1, 100 + i, 1'b0, 1'b0);
    check("R3 count held at 32", int'(count), 32);
    check("R3 oldest dropped", int'(rdData), 108);
    cyc(1'b1, 200, 1'b0, 1'b1);
    check("R4 push+pop full count", int'(count), 32);
    check("R4 push+pop next oldest", int'(rdData), 109);
    cyc(1'b0, 0, 1'b0, 1'b1);
    check("R3 overrun sticky after pop", int'(overrun), 1);
  endtask

  task automatic testBypass();
    mode = 2'b00;
    cyc(1'b1, 77, 1'b0, 1'b1);
    check("R1 bypass count", int'(count), 0);
    check("R1 bypass overrun", int'(overrun), 0);
    cyc(1'b1, 78, 1'b0, 1'b0);
    check("R1 bypass ignores push", int'(count), 0);
    mode = 2'b11;
    cyc(1'b1, 79, 1'b0, 1'b0);
    check("R1 code 11 acts as bypass", int'(count), 0);
  endtask

  task automatic testTrigFull();
    setMode(2'b00);
    setMode(2'b10);
    for (int i = 0; i < 35; i++) begin
      if (i == 20) cyc(1'b0, 0, 1'b1, 1'b0);  // trigger without valid: R9
      cyc(1'b1, 300 + i, 1'b0, 1'b0);
    end
    cyc(1'b1, 335, 1'b1, 1'b0);
    check("R5 not frozen on trigger sample", int'(frozen), 0);
    cyc(1'b1, 336, 1'b0, 1'b0);
    check("R5 frozen after post sample", int'(frozen), 1);
    for (int i = 37; i < 40; i++) cyc(1'b1, 300 + i, 1'b0, 1'b0);
    check("R8 discarded while frozen", int'(count), 32);
    check("R5 first pre sample", int'(rdData), 305);
    check("R9 first pre sample unmarked", int'(rdIsTrig), 0);
    // push during pop on a frozen store
    cyc(1'b1, 999, 1'b0, 1'b1);
    check("R8 pop drains while frozen", int'(count), 31);
    for (int k = 1; k < 32; k++)
      popExpect("R5 frozen content", 305 + k, (k == 30) ? 1 : 0);
    check("R8 fully drained", int'(count), 0);
    check("R8 still frozen", int'(frozen), 1);
    cyc(1'b1, 555, 1'b0, 1'b0);
    check("R8 empty frozen ignores push", int'(count), 0);
    setMode(2'b00);
    check("R1 bypass clears frozen", int'(frozen), 0);
  endtask

  task automatic testTrigDropped();
    setMode(2'b10);
    for (int i = 0; i < 40; i++) cyc(1'b1, 400 + i, (i == 3), 1'b0);
    check("R7 no freeze", int'(frozen), 0);
    check("R7 overrun", int'(overrun), 1);
    check("R7 kept overwriting", int'(rdData), 408);
    setMode(2'b00);
  endtask

  task automatic testTrigHeld();
    setMode(2'b10);
    for (int i = 0; i < 31; i++) cyc(1'b1, 500 + i, (i >= 3), 1'b0);
    check("R6 not frozen before fill", int'(frozen), 0);
    cyc(1'b1, 531, 1'b1, 1'b0);
    check("R6 frozen at fill", int'(frozen), 1);
    check("R6 count", int'(count), 32);
    cyc(1'b1, 532, 1'b1, 1'b0);
    check("R8 extra sample discarded", int'(count), 32);
    for (int k = 0; k < 3; k++) popExpect("R9 unmarked early", 500 + k, 0);
    popExpect("R9 marked trigger sample", 503, 1);
    setMode(2'b00);
  endtask

  task automatic testStreamIgnoresTrig();
    setMode(2'b01);
    for (int i = 0; i < 40; i++) cyc(1'b1, 600 + i, 1'b1, 1'b0);
    check("R10 no freeze in stream", int'(frozen), 0);
    check("R10 count", int'(count), 32);
    check("R10 oldest", int'(rdData), 608);
    check("R10 mark clear", int'(rdIsTrig), 0);
    setMode(2'b00);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStream();
    testOverflow();
    testBypass();
    testTrigFull();
    testTrigDropped();
    testTrigHeld();
    testStreamIgnoresTrig();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule